// File: doc/BRIEF.md
# Soft Reset Control and Status Register

This block keeps one 32-bit reset control and status word behind a plain register write/read port and turns software commands into system reset requests. Three status bits are cleared by writing ones to them, two command bits are stored straight from the write data, and every other bit ignores writes. Writing either command bit produces a single-clock `rst_req` pulse. An external reset sequencer acts on that pulse and later drives `sys_rst`.

A saturating counter records how many system resets have occurred since the last power-on command. The power-on status flag is loaded only when a system reset arrives while the counter is zero. A system reset is recognised on the rising edge of `sys_rst`. While `sys_rst` is high, the register port does not accept writes. The asynchronous `rst_n` input is the true power-up reset. It clears the word and the counter, so the first system reset afterwards is reported as a power-on reset.

There is no flow of data through the block, so the port has no valid/ready handshake. A write is accepted in any cycle in which `wr_en` is high and `sys_rst` is low.

Top module: `srst_ctrl`

## Requirements
- R1: Bits 31, 28 and 27 clear when a write has a 1 in that position. A 0 in that position leaves the bit unchanged, and a write never sets these bits.
- R2: Bits 30 and 29 take the value of the written data in every accepted write.
- R3: Bits 26 down to 0 are never changed by writes. After power-up they read 0.
- R4: An accepted write with bit 30 set pulses `rst_req` high for exactly one cycle, in the cycle after the write. The same write clears the reset counter.
- R5: An accepted write with bit 30 clear and bit 29 set pulses `rst_req` in the same way. This write leaves the reset counter unchanged.
- R6: An accepted write with bits 30 and 29 both clear does not raise `rst_req`.
- R7: A rising edge on `sys_rst` while the counter is zero loads the word with 0x80000000. A rising edge while the counter is nonzero leaves the word unchanged. Every rising edge increments the counter.
- R8: The counter holds at its maximum value (2^CNT_W-1, which is 15 by default). Any number of further system resets therefore never reports a power-on reset.
- R9: While `rst_n` is low, `rd_data` reads 0 and `rst_req` is 0. The counter is zero when `rst_n` is released. `rd_data` always shows the current word.
- R10: A write presented while `sys_rst` is high is ignored. It changes no bit, raises no request and does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| sys_rst | input | 1 | System reset level from the sequencer; its rising edge is a reset event |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A register write and a system reset event can occur in the same cycle. The bench provokes this by raising `sys_rst` and presenting an all-ones write in the same cycle, with the counter both zero and nonzero. It checks that the word shows only the power-on load, or no change, and that `rst_req` stays low. It then applies a reset with no power-on command before it, which confirms that the colliding write did not clear the counter.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [REG_W-1:0] CLR1_MASK = 32'h9800_0000;
  localparam logic [REG_W-1:0] LOAD_MASK = 32'h6000_0000;
  localparam logic [REG_W-1:0] PWRON_VAL = 32'h8000_0000;
  localparam int unsigned CMD_PWR_BIT = 30;
  localparam int unsigned CMD_EXT_BIT = 29;

  typedef enum logic [1:0] {
    FLD_KEEP = 2'd0,
    FLD_CLR1 = 2'd1,
    FLD_LOAD = 2'd2
  } fld_kind_e;

  function automatic fld_kind_e kind_of(input int unsigned b);
    if (CLR1_MASK[b]) return FLD_CLR1;
    if (LOAD_MASK[b]) return FLD_LOAD;
    return FLD_KEEP;
  endfunction
endpackage

// File: rtl/srst_field_merge.sv
module srst_field_merge
  import srst_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] nxt
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (kind_of(b) == FLD_CLR1) begin : g_clr1
      assign nxt[b] = cur[b] & ~wdata[b];
    end else if (kind_of(b) == FLD_LOAD) begin : g_load
      assign nxt[b] = wdata[b];
    end else begin : g_keep
      assign nxt[b] = cur[b];
    end
  end
endmodule

// File: rtl/srst_rst_count.sv
module srst_rst_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic is_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr) begin
      cnt_q <= '0;
    end
  end

  assign is_zero = (cnt_q == '0);

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX) || $past(clr && !inc));

  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt_q == '0));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             sys_rst,
  output logic             rst_req
);
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] ctl_merged;
  logic             sys_rst_q;
  logic             rst_evt;
  logic             wr_ok;
  logic             cnt_zero;
  logic             req_q;

  assign rst_evt = sys_rst & ~sys_rst_q;
  assign wr_ok   = wr_en & ~sys_rst;

  srst_field_merge #(.W(REG_W)) u_merge (
    .cur   (ctl_q),
    .wdata (wr_data),
    .nxt   (ctl_merged)
  );

  srst_rst_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wr_ok & wr_data[CMD_PWR_BIT]),
    .inc     (rst_evt),
    .is_zero (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_q <= 1'b0;
      ctl_q     <= '0;
      req_q     <= 1'b0;
    end else begin
      sys_rst_q <= sys_rst;
      req_q     <= wr_ok & (wr_data[CMD_PWR_BIT] | wr_data[CMD_EXT_BIT]);
      if (rst_evt) begin
        if (cnt_zero) ctl_q <= PWRON_VAL;
      end else if (wr_ok) begin
        ctl_q <= ctl_merged;
      end
    end
  end

  assign rd_data = ctl_q;
  assign rst_req = req_q;

  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_en && !sys_rst &&
                      (wr_data[CMD_PWR_BIT] || wr_data[CMD_EXT_BIT])));

  p_no_req_in_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !rst_req);

  p_clr1_never_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_evt |=> ((ctl_q & CLR1_MASK & ~$past(ctl_q)) == '0));

  p_keep_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ctl_q[26:0] == '0));

  p_pwron_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && cnt_zero) |=> (ctl_q == PWRON_VAL));

  p_hold_on_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !cnt_zero) |=> $stable(ctl_q));
endmodule

// File: tb/test_srst_ctrl.sv
module test_srst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_MAX    = 15;
  localparam int WDOG_LIMIT = 20000;
  localparam logic [31:0] CLR1 = 32'h9800_0000;
  localparam logic [31:0] LOAD = 32'h6000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        sys_rst = 1'b0;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] exp_reg = '0;
  int exp_cnt = 0;

  srst_ctrl #(.CNT_W(4)) i_srst_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sys_rst(sys_rst), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // accepted write: model update, then check word and pulse timing
  task automatic do_write(input logic [31:0] wd, input string tag);
    logic exp_req;
    @(negedge clk);
    wr_en = 1'b1; wr_data = wd;
    exp_reg = (exp_reg & ~(wd & CLR1) & ~LOAD) | (wd & LOAD);
    exp_req = wd[30] | wd[29];
    if (wd[30]) exp_cnt = 0;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check(tag, rd_data, exp_reg);
    check(exp_req ? (wd[30] ? "R4" : "R5") : "R6", {31'b0, rst_req}, {31'b0, exp_req});
    @(negedge clk);
    check("R4", {31'b0, rst_req}, 32'b0);
  endtask

  // system reset event, optionally with a colliding write
  task automatic do_sysrst(input logic collide);
    @(negedge clk);
    sys_rst = 1'b1;
    if (collide) begin wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; end
    if (exp_cnt == 0) exp_reg = 32'h8000_0000;
    if (exp_cnt < CNT_MAX) exp_cnt++;
    @(negedge clk);
    check("R7", rd_data, exp_reg);
    check("R10", {31'b0, rst_req}, 32'b0);
    if (collide) begin
      @(negedge clk);
      check("R10", rd_data, exp_reg);
      check("R10", {31'b0, rst_req}, 32'b0);
    end
    wr_en = 1'b0; wr_data = '0; sys_rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*2);
    check("R9", rd_data, 32'h0);
    check("R9", {31'b0, rst_req}, 32'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9", rd_data, 32'h0);

    // first reset after power-up reports power-on
    do_sysrst(1'b0);
    check("R9", rd_data, 32'h8000_0000);
    // second reset leaves the word
    do_write(32'h8000_0000, "R1");
    do_sysrst(1'b0);

    // sweep upper five bits, with two low patterns, with/without soft POR refresh
    for (int w = 0; w < 32; w++) begin
      for (int lo = 0; lo < 2; lo++) begin
        logic [31:0] wd;
        wd = {w[4:0], (lo == 0) ? 27'h0 : 27'h7FF_FFFF};
        if (w[0]) begin
          do_write(32'h4000_0000, "R4");
          do_sysrst(1'b0);
        end
        do_write(wd, w[4] ? "R1" : (lo == 1 ? "R3" : "R2"));
      end
    end

    // ext-only command keeps counter: following reset must not load POR
    do_write(32'h4000_0000, "R4");
    do_sysrst(1'b0);
    do_write(32'h8000_0000, "R1");
    do_write(32'h2000_0000, "R5");
    do_sysrst(1'b0);
    check("R5", rd_data, 32'h2000_0000);

    // collision with counter zero and nonzero
    do_write(32'h4000_0000, "R4");
    do_sysrst(1'b1);
    do_write(32'h8000_0000, "R1");
    do_sysrst(1'b1);
    do_sysrst(1'b0);
    check("R10", rd_data, 32'h0000_0000);

    // saturation: many resets, never a power-on load
    do_write(32'h4000_0000, "R4");
    do_sysrst(1'b0);
    do_write(32'h8000_0000, "R1");
    for (int k = 0; k < 20; k++) begin
      do_sysrst(1'b0);
      check("R8", rd_data, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule